// File: doc/BRIEF.md
# Reset Configuration Word Sequencer

During hard reset, the device that acts as configuration master has to collect a configuration word for itself and for up to seven slave devices. All of these words come from one boot memory on chip-select 0. The memory's port width is not known at this stage, so the sequencer reads every byte as a single-byte access. It takes the byte from byte lane 0 of the memory data bus. Byte k of the word for device n is read from address n*0x20 + k*0x08. Any memory width sees that address on lane 0.

Device 0 is the master. Its word is fetched first and kept on a dedicated output. The word for each slave is then assembled in turn and driven on a 32-bit data bus. Strobe line n-1 then gives an active-low pulse, which the slave uses to latch the word. Eight words are always fetched, however many slaves are fitted. The sequencer then raises a done flag and stops driving the bus. Synchronous reset aborts a sequence in progress and starts it again from the first byte.

Top module: `cfg_word_sequencer`

## Requirements
- R1: Each configuration byte is taken from `mem_data` (byte lane 0) in the cycle where `mem_rdy` is high during a read. Exactly one byte is accepted per ready cycle.
- R2: The byte with index k (0..3) of the word for device n (0..7) is read from address n*0x20 + k*0x08. Every read address is therefore a multiple of 8.
- R3: The fetch order is ascending: device 0 first, then devices 1 to 7, and within a word byte 0 to byte 3. Byte 0 becomes bits 31:24 of the assembled word and byte 3 becomes bits 7:0.
- R4: Exactly 32 byte reads (eight words) are made after each reset. `done` then goes high and stays high, and no further read or strobe follows.
- R5: Slave n (1..7) is strobed on `slv_strobe_n[n-1]` with exactly one low pulse of one clock, and its word is on the bus during the pulse. At no time is more than one strobe line low.
- R6: `mem_cs0_n` is low in every cycle where `mem_rd` is high, and high once the sequence is complete.
- R7: After the fourth byte of device 0 is accepted, `own_word` holds the master word and `own_valid` is high. Once `done` is high, `cfg_bus_oe` is low (the bus is released to high impedance).
- R8: `cfg_bus_oe` is high and `cfg_bus_data` holds the slave word for at least one clock before the strobe pulse, throughout it, and for one clock after it.
- R9: While a read waits for `mem_rdy`, `mem_addr` and the read request stay unchanged.
- R10: While `rst` is high, all strobes are high, `cfg_bus_oe`, `mem_rd`, `own_valid` and `done` are low, and `mem_cs0_n` is high. Once `rst` is released, the sequence restarts at address 0x00, even if reset arrived in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mem_addr | output | ADDR_W | Byte address to the boot memory |
| mem_cs0_n | output | 1 | Chip-select 0, active low |
| mem_rd | output | 1 | Read request |
| mem_rdy | input | 1 | Read data valid, ends the access |
| mem_data | input | 8 | Memory byte lane 0 |
| cfg_bus_data | output | 32 | Slave configuration word on the data bus |
| cfg_bus_oe | output | 1 | Data bus output enable (low means high impedance) |
| slv_strobe_n | output | NUM_DEVICES-1 | Active-low latch strobes, bit n-1 for slave n |
| own_word | output | 32 | Master's own configuration word |
| own_valid | output | 1 | `own_word` is valid |
| done | output | 1 | All eight words have been handled |

## Verification
The memory model returns a byte that is a function of the address and a seed. A wrong address, lane or byte order therefore shows up as a wrong word, either at `own_word` or on the bus while a strobe is low. One pass with a ready in every access checks the plain order and the strobe framing. A second pass uses a three-cycle ready latency and a different seed, so a sequencer that does not wait for ready or does not hold its address is exposed. A reset in the middle of the slave phase, followed by a full run, separates a clean restart from one that resumes at a stale device index. Watching the ports after `done` separates a fixed count of eight words from a free-running fetch loop.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam int CFG_BYTE_W      = 8;
    localparam int CFG_NUM_DEVICES = 8;
    localparam int CFG_BYTES_WORD  = 4;
    localparam int CFG_DEV_STRIDE  = 32;
    localparam int CFG_BYTE_STRIDE = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_DONE
    } seq_state_e;

    // Byte address of byte 'bsel' of the word belonging to device 'dev'.
    function automatic int cfg_byte_addr(input int dev, input int bsel,
                                         input int dstride, input int bstride);
        return dev * dstride + bsel * bstride;
    endfunction

endpackage

// File: rtl/cfgseq_addr_gen.sv
module cfgseq_addr_gen
    import cfgseq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DEV_W       = 3,
    parameter int BSEL_W      = 2,
    parameter int DEV_STRIDE  = CFG_DEV_STRIDE,
    parameter int BYTE_STRIDE = CFG_BYTE_STRIDE
) (
    input  logic [DEV_W-1:0]  dev,
    input  logic [BSEL_W-1:0] bsel,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = ADDR_W'(cfg_byte_addr(int'(dev), int'(bsel), DEV_STRIDE, BYTE_STRIDE));
    end
endmodule

// File: rtl/cfgseq_word_asm.sv
module cfgseq_word_asm
    import cfgseq_pkg::*;
#(
    parameter int BYTES = CFG_BYTES_WORD
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [CFG_BYTE_W-1:0]       byte_in,
    output logic [BYTES*CFG_BYTE_W-1:0] next_word
);
    localparam int WORD_W = BYTES * CFG_BYTE_W;

    logic [WORD_W-1:0] word_q;

    // First byte read ends up in the most significant position.
    always_comb begin
        next_word = {word_q[WORD_W-CFG_BYTE_W-1:0], byte_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= next_word;
        end
    end
endmodule

// File: rtl/cfgseq_strobe_drv.sv
module cfgseq_strobe_drv #(
    parameter int NUM_SLAVES = 7,
    parameter int DEV_W      = 3
) (
    input  logic                  active,
    input  logic [DEV_W-1:0]      dev,
    output logic [NUM_SLAVES-1:0] strobe_n
);
    for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_line
        assign strobe_n[i] = !(active && (dev == DEV_W'(i + 1)));
    end
endmodule

// File: rtl/cfg_word_sequencer.sv
module cfg_word_sequencer
    import cfgseq_pkg::*;
#(
    parameter int NUM_DEVICES    = CFG_NUM_DEVICES,
    parameter int BYTES_PER_WORD = CFG_BYTES_WORD,
    parameter int ADDR_W         = 8,
    parameter int DEV_STRIDE     = CFG_DEV_STRIDE,
    parameter int BYTE_STRIDE    = CFG_BYTE_STRIDE,
    parameter int SETUP_CYC      = 1,
    parameter int PULSE_CYC      = 1,
    parameter int HOLD_CYC       = 1
) (
    input  logic                                 clk,
    input  logic                                 rst,
    output logic [ADDR_W-1:0]                    mem_addr,
    output logic                                 mem_cs0_n,
    output logic                                 mem_rd,
    input  logic                                 mem_rdy,
    input  logic [CFG_BYTE_W-1:0]                mem_data,
    output logic [BYTES_PER_WORD*CFG_BYTE_W-1:0] cfg_bus_data,
    output logic                                 cfg_bus_oe,
    output logic [NUM_DEVICES-2:0]               slv_strobe_n,
    output logic [BYTES_PER_WORD*CFG_BYTE_W-1:0] own_word,
    output logic                                 own_valid,
    output logic                                 done
);
    localparam int WORD_W     = BYTES_PER_WORD * CFG_BYTE_W;
    localparam int NUM_SLAVES = NUM_DEVICES - 1;
    localparam int DEV_W      = $clog2(NUM_DEVICES);
    localparam int BSEL_W     = $clog2(BYTES_PER_WORD);
    localparam int PH_W       = $clog2(SETUP_CYC + PULSE_CYC + HOLD_CYC + 1);

    seq_state_e        state_q;
    logic [DEV_W-1:0]  dev_q;
    logic [BSEL_W-1:0] bsel_q;
    logic [PH_W-1:0]   ph_q;
    logic [WORD_W-1:0] own_q;
    logic              own_vld_q;
    logic [WORD_W-1:0] bus_q;
    logic [WORD_W-1:0] asm_next;
    logic              accept;
    logic              last_byte;

    assign accept    = (state_q == ST_FETCH) && mem_rdy;
    assign last_byte = (bsel_q == BSEL_W'(BYTES_PER_WORD - 1));

    cfgseq_addr_gen #(
        .ADDR_W     (ADDR_W),
        .DEV_W      (DEV_W),
        .BSEL_W     (BSEL_W),
        .DEV_STRIDE (DEV_STRIDE),
        .BYTE_STRIDE(BYTE_STRIDE)
    ) u_addr (
        .dev (dev_q),
        .bsel(bsel_q),
        .addr(mem_addr)
    );

    cfgseq_word_asm #(
        .BYTES(BYTES_PER_WORD)
    ) u_asm (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .byte_in  (mem_data),
        .next_word(asm_next)
    );

    cfgseq_strobe_drv #(
        .NUM_SLAVES(NUM_SLAVES),
        .DEV_W     (DEV_W)
    ) u_strobe (
        .active  (state_q == ST_PULSE),
        .dev     (dev_q),
        .strobe_n(slv_strobe_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            dev_q     <= '0;
            bsel_q    <= '0;
            ph_q      <= '0;
            own_q     <= '0;
            own_vld_q <= 1'b0;
            bus_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    dev_q   <= '0;
                    bsel_q  <= '0;
                    state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (mem_rdy) begin
                        if (!last_byte) begin
                            bsel_q <= bsel_q + 1'b1;
                        end else begin
                            bsel_q <= '0;
                            if (dev_q == '0) begin
                                own_q     <= asm_next;
                                own_vld_q <= 1'b1;
                                dev_q     <= dev_q + 1'b1;
                            end else begin
                                bus_q   <= asm_next;
                                ph_q    <= '0;
                                state_q <= ST_SETUP;
                            end
                        end
                    end
                end
                ST_SETUP: begin
                    if (ph_q == PH_W'(SETUP_CYC - 1)) begin
                        ph_q    <= '0;
                        state_q <= ST_PULSE;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (ph_q == PH_W'(PULSE_CYC - 1)) begin
                        ph_q    <= '0;
                        state_q <= ST_HOLD;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (ph_q == PH_W'(HOLD_CYC - 1)) begin
                        ph_q <= '0;
                        if (dev_q == DEV_W'(NUM_DEVICES - 1)) begin
                            state_q <= ST_DONE;
                        end else begin
                            dev_q   <= dev_q + 1'b1;
                            state_q <= ST_FETCH;
                        end
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_DONE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        mem_rd       = (state_q == ST_FETCH);
        mem_cs0_n    = !mem_rd;
        cfg_bus_oe   = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
        cfg_bus_data = bus_q;
        own_word     = own_q;
        own_valid    = own_vld_q;
        done         = (state_q == ST_DONE);
    end

endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker #(
    parameter int NUM_DEVICES = 8,
    parameter int ADDR_W      = 8,
    parameter int WORD_W      = 32,
    parameter int BYTE_STRIDE = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic                   mem_cs0_n,
    input logic                   mem_rd,
    input logic                   mem_rdy,
    input logic [WORD_W-1:0]      cfg_bus_data,
    input logic                   cfg_bus_oe,
    input logic [NUM_DEVICES-2:0] slv_strobe_n,
    input logic                   own_valid,
    input logic                   done
);
    assert_cs_on_read_R6: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !mem_cs0_n);

    assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> ((int'(mem_addr) % BYTE_STRIDE) == 0));

    assert_addr_held_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(~slv_strobe_n) <= 1);

    assert_bus_on_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (slv_strobe_n != '1) |-> (cfg_bus_oe && $past(cfg_bus_oe) && $stable(cfg_bus_data)));

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cfg_bus_oe && !mem_rd && (slv_strobe_n == '1)));

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        own_valid |=> own_valid);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!mem_rd && !cfg_bus_oe && !done && (slv_strobe_n == '1)));
endmodule

bind cfg_word_sequencer cfgseq_checker #(
    .NUM_DEVICES(NUM_DEVICES),
    .ADDR_W     (ADDR_W),
    .WORD_W     (BYTES_PER_WORD * 8),
    .BYTE_STRIDE(BYTE_STRIDE)
) u_cfgseq_checker (
    .clk         (clk),
    .rst         (rst),
    .mem_addr    (mem_addr),
    .mem_cs0_n   (mem_cs0_n),
    .mem_rd      (mem_rd),
    .mem_rdy     (mem_rdy),
    .cfg_bus_data(cfg_bus_data),
    .cfg_bus_oe  (cfg_bus_oe),
    .slv_strobe_n(slv_strobe_n),
    .own_valid   (own_valid),
    .done        (done)
);

// File: tb/tb_cfg_word_sequencer.sv
module tb_cfg_word_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV       = 8;
    localparam int NREADS     = NDEV * 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic        mem_cs0_n;
    logic        mem_rd;
    logic        mem_rdy = 1'b0;
    logic [7:0]  mem_data = 8'h00;
    logic [31:0] cfg_bus_data;
    logic        cfg_bus_oe;
    logic [6:0]  slv_strobe_n;
    logic [31:0] own_word;
    logic        own_valid;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;
    int lat      = 0;
    int seed_mul = 7;
    int seed_off = 3;

    // monitor logs
    int          rd_cnt;
    logic [7:0]  rd_addr_log [64];
    int          wait_cnt;
    logic [7:0]  wait_addr;
    bit          hold_err;
    bit          cs_err;
    int          stb_cnt;
    int          stb_line  [16];
    logic [31:0] stb_data  [16];
    bit          stb_setup [16];
    bit          stb_hold  [16];
    int          stb_len   [16];
    int          low_len;
    bit          stb_multi;
    logic [6:0]  prev_stb = '1;
    logic        prev_oe = 1'b0;
    logic [31:0] prev_data = '0;

    cfg_word_sequencer dut (
        .clk         (clk),
        .rst         (rst),
        .mem_addr    (mem_addr),
        .mem_cs0_n   (mem_cs0_n),
        .mem_rd      (mem_rd),
        .mem_rdy     (mem_rdy),
        .mem_data    (mem_data),
        .cfg_bus_data(cfg_bus_data),
        .cfg_bus_oe  (cfg_bus_oe),
        .slv_strobe_n(slv_strobe_n),
        .own_word    (own_word),
        .own_valid   (own_valid),
        .done        (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        return 8'(a * seed_mul + seed_off);
    endfunction

    function automatic int exp_addr(input int i);
        return (i / 4) * 32 + (i % 4) * 8;
    endfunction

    function automatic logic [31:0] exp_word(input int d);
        return {pat(d * 32), pat(d * 32 + 8), pat(d * 32 + 16), pat(d * 32 + 24)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        rd_cnt    = 0;
        wait_cnt  = 0;
        hold_err  = 0;
        cs_err    = 0;
        stb_cnt   = 0;
        stb_multi = 0;
        low_len   = 0;
    endtask

    // Memory model and port monitor, all on the falling edge.
    always @(negedge clk) begin
        if (rst) begin
            mem_rdy  = 1'b0;
            wait_cnt = 0;
        end else begin
            if (mem_rd && mem_cs0_n) cs_err = 1;
            if (mem_rdy) begin
                mem_rdy  = 1'b0;
                wait_cnt = 0;
            end else if (mem_rd) begin
                if (wait_cnt > 0 && mem_addr != wait_addr) hold_err = 1;
                wait_addr = mem_addr;
                if (wait_cnt >= lat) begin
                    mem_rdy  = 1'b1;
                    mem_data = pat(int'(mem_addr));
                    if (rd_cnt < 64) rd_addr_log[rd_cnt] = mem_addr;
                    rd_cnt++;
                end else begin
                    wait_cnt++;
                end
            end
            if ($countones(~slv_strobe_n) > 1) stb_multi = 1;
            for (int i = 0; i < 7; i++) begin
                if (!slv_strobe_n[i] && prev_stb[i]) begin
                    if (stb_cnt < 16) begin
                        stb_line[stb_cnt]  = i;
                        stb_data[stb_cnt]  = cfg_bus_data;
                        stb_setup[stb_cnt] = prev_oe && cfg_bus_oe && (prev_data == cfg_bus_data);
                    end
                    low_len = 1;
                end else if (!slv_strobe_n[i] && !prev_stb[i]) begin
                    low_len++;
                end else if (slv_strobe_n[i] && !prev_stb[i]) begin
                    if (stb_cnt < 16) begin
                        stb_hold[stb_cnt] = cfg_bus_oe && (cfg_bus_data == stb_data[stb_cnt]);
                        stb_len[stb_cnt]  = low_len;
                    end
                    stb_cnt++;
                end
            end
        end
        prev_stb  = slv_strobe_n;
        prev_oe   = cfg_bus_oe;
        prev_data = cfg_bus_data;
    end

    task automatic check_reset_state(input string tag);
        chk(slv_strobe_n == 7'h7F, {"R10 strobes idle ", tag}, 32'(slv_strobe_n), 32'h7F);
        chk(!cfg_bus_oe && !mem_rd && mem_cs0_n, {"R10 bus/read idle ", tag},
            {29'd0, cfg_bus_oe, mem_rd, mem_cs0_n}, 32'h1);
        chk(!own_valid && !done, {"R10 flags low ", tag}, {30'd0, own_valid, done}, 32'h0);
    endtask

    task automatic wait_done();
        for (int c = 0; c < 4000 && !done; c++) @(negedge clk);
    endtask

    task automatic verify_run(input string tag);
        int bad;
        chk(done, {"R4 done reached ", tag}, 32'(done), 32'h1);
        chk(rd_cnt == NREADS, {"R4 read count ", tag}, 32'(rd_cnt), 32'(NREADS));
        bad = 0;
        for (int i = 0; i < NREADS && i < rd_cnt; i++)
            if (int'(rd_addr_log[i]) != exp_addr(i)) begin
                if (bad == 0)
                    chk(0, {"R2 R3 address order ", tag}, 32'(rd_addr_log[i]), 32'(exp_addr(i)));
                bad++;
            end
        if (bad == 0) chk(1, "R2 R3", 0, 0);
        chk(!hold_err, {"R9 address held while waiting ", tag}, 32'(hold_err), 0);
        chk(!cs_err, {"R6 chip select with read ", tag}, 32'(cs_err), 0);
        chk(own_valid, {"R7 own_valid ", tag}, 32'(own_valid), 1);
        chk(own_word == exp_word(0), {"R1 R3 R7 own word ", tag}, own_word, exp_word(0));
        chk(stb_cnt == NDEV - 1, {"R5 strobe count ", tag}, 32'(stb_cnt), 32'(NDEV - 1));
        chk(!stb_multi, {"R5 single strobe low ", tag}, 32'(stb_multi), 0);
        for (int s = 0; s < NDEV - 1 && s < stb_cnt; s++) begin
            chk(stb_line[s] == s, {"R5 strobe line order ", tag}, 32'(stb_line[s]), 32'(s));
            chk(stb_data[s] == exp_word(s + 1), {"R1 R3 slave word ", tag}, stb_data[s],
                exp_word(s + 1));
            chk(stb_len[s] == 1, {"R5 pulse width ", tag}, 32'(stb_len[s]), 1);
            chk(stb_setup[s] && stb_hold[s], {"R8 bus setup/hold ", tag},
                {30'd0, stb_setup[s], stb_hold[s]}, 32'h3);
        end
        chk(!cfg_bus_oe, {"R7 bus released ", tag}, 32'(cfg_bus_oe), 0);
        chk(mem_cs0_n && !mem_rd, {"R6 chip select idle after done ", tag},
            {30'd0, mem_cs0_n, mem_rd}, 32'h2);
        repeat (20) @(negedge clk);
        chk(rd_cnt == NREADS && stb_cnt == NDEV - 1 && done, {"R4 quiet after done ", tag},
            32'(rd_cnt), 32'(NREADS));
    endtask

    task automatic start_run(input int l, input int m, input int o);
        @(negedge clk);
        rst = 1'b1;
        lat = l;
        seed_mul = m;
        seed_off = o;
        repeat (3) @(negedge clk);
        check_reset_state("in reset");
        clear_logs();
        rst = 1'b0;
    endtask

    task automatic test_ready_every_access();
        start_run(0, 7, 3);
        wait_done();
        verify_run("lat0");
    endtask

    task automatic test_slow_memory();
        start_run(3, 13, 8'h5C);
        wait_done();
        verify_run("lat3");
    endtask

    task automatic test_abort_midway();
        start_run(1, 29, 8'h11);
        for (int c = 0; c < 4000 && stb_cnt < 3; c++) @(negedge clk);
        chk(stb_cnt >= 3 && !done, "R10 midway point reached", 32'(stb_cnt), 3);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_reset_state("abort");
        clear_logs();
        seed_mul = 5;
        seed_off = 8'h77;
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(mem_rd && mem_addr == 8'h00, "R10 restart at 0x00", 32'(mem_addr), 0);
        wait_done();
        verify_run("restart");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        clear_logs();
        repeat (3) @(negedge clk);
        check_reset_state("power-up");
        test_ready_every_access();
        test_slow_memory();
        test_abort_midway();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule